// File: doc/BRIEF.md
# Operate Microinstruction Accumulator Unit

This block carries out one operate-group microinstruction on an 18-bit accumulator (AC) and its one-bit Link. The low 13 bits of the instruction word are a set of independent action bits. Several can be set at once: clears, complements, an inclusive OR with the console switch word, one- or two-place rotates of the 19-bit AC+Link ring, a halt request and a conditional skip. The block applies them in a fixed order of events, so combined actions on the same register give one defined result.

The sequencer presents the instruction, the current AC and Link and the switch value, then pulses `start` for one cycle. One clock later `done` is high for one cycle. At that point the new AC and Link are on the outputs, together with a skip request (the sequencer steps past the next instruction) and a halt request. Between operations the outputs hold their last values. The five opcode bits above the action field are not examined.

Top module: `opr_unit`

## Requirements
- R1: `done` is high exactly in the cycle after a cycle with `start` high. `ac_out`, `link_out`, `skip_req` and `halt_req` change only in that cycle and otherwise hold their values.
- R2: Skip conditions are tested on the AC and Link as presented, before any action applies. Bit 6 (octal 100) selects "AC bit 17 is 1", bit 7 (octal 200) selects "AC is zero" and bit 8 (octal 400) selects "Link is 1". With bit 9 clear, `skip_req` is 1 if any selected condition is true.
- R3: With bit 9 (octal 1000) set, `skip_req` is 1 only if every selected condition is false. Bit 9 with no condition bit set is an unconditional skip.
- R4: Clears act first: bit 12 (octal 10000) zeroes the AC and bit 11 (octal 4000) zeroes the Link.
- R5: Complements act after the clears: bit 0 (octal 1) inverts the AC and bit 1 (octal 2) inverts the Link. Clear plus complement gives all ones.
- R6: Bit 2 (octal 4) ORs the switch word into the AC after any complement.
- R7: Rotates act last, on the 19-bit ring with the Link above AC bit 17. Bit 3 (octal 10) rotates left: the Link enters AC bit 0 and AC bit 17 enters the Link. Bit 4 (octal 20) rotates right: the Link enters AC bit 17 and AC bit 0 enters the Link.
- R8: Bit 10 (octal 2000) makes a selected rotate move two places. With no rotate selected it has no effect.
- R9: When bits 3 and 4 are both set, no rotation takes place.
- R10: `halt_req` equals bit 5 (octal 40) of the instruction of the last operation.
- R11: After reset, `ac_out`, `link_out`, `skip_req`, `halt_req` and `done` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to execute `instr` |
| instr | input | 18 | Instruction word; bits 12..0 are the action field |
| ac_in | input | 18 | Accumulator value before the operation |
| link_in | input | 1 | Link value before the operation |
| sw | input | 18 | Console switch word |
| ac_out | output | 18 | Accumulator after the operation |
| link_out | output | 1 | Link after the operation |
| skip_req | output | 1 | Request to skip the next instruction |
| halt_req | output | 1 | Request to halt |
| done | output | 1 | Results valid, one cycle after `start` |

## Verification
The result register is the only state, so a wrong event order or a wrong skip sense shows at the ports in the `done` cycle of the operation that triggers it. The bench therefore sets bits that interact: a clear with a complement, a clear with a rotate, a complement with the switch OR, and a skip condition with a clear that would hide it if tested late. A result register that is loaded outside the `done` cycle shows up as output drift in the idle cycles that follow.

// File: rtl/opr_pkg.sv
package opr_pkg;
  // action field width and positions; the positions are the encoding
  localparam int unsigned OPR_FIELD_W = 13;
  localparam int unsigned B_CPL_AC  = 0;
  localparam int unsigned B_CPL_LK  = 1;
  localparam int unsigned B_OR_SW   = 2;
  localparam int unsigned B_ROT_L   = 3;
  localparam int unsigned B_ROT_R   = 4;
  localparam int unsigned B_HALT    = 5;
  localparam int unsigned B_T_MINUS = 6;
  localparam int unsigned B_T_ZERO  = 7;
  localparam int unsigned B_T_LINK  = 8;
  localparam int unsigned B_INVERT  = 9;
  localparam int unsigned B_TWICE   = 10;
  localparam int unsigned B_CLR_LK  = 11;
  localparam int unsigned B_CLR_AC  = 12;

  typedef struct packed {
    logic clr_ac;
    logic clr_lk;
    logic twice;
    logic invert;
    logic t_link;
    logic t_zero;
    logic t_minus;
    logic halt;
    logic rot_r;
    logic rot_l;
    logic or_sw;
    logic cpl_lk;
    logic cpl_ac;
  } opr_ctl_t;
endpackage

// File: rtl/opr_decode.sv
module opr_decode
  import opr_pkg::*;
(
  input  logic [OPR_FIELD_W-1:0] field,
  output opr_ctl_t               ctl
);
  always_comb begin
    ctl.cpl_ac  = field[B_CPL_AC];
    ctl.cpl_lk  = field[B_CPL_LK];
    ctl.or_sw   = field[B_OR_SW];
    ctl.rot_l   = field[B_ROT_L];
    ctl.rot_r   = field[B_ROT_R];
    ctl.halt    = field[B_HALT];
    ctl.t_minus = field[B_T_MINUS];
    ctl.t_zero  = field[B_T_ZERO];
    ctl.t_link  = field[B_T_LINK];
    ctl.invert  = field[B_INVERT];
    ctl.twice   = field[B_TWICE];
    ctl.clr_lk  = field[B_CLR_LK];
    ctl.clr_ac  = field[B_CLR_AC];
  end
endmodule

// File: rtl/opr_skip.sv
module opr_skip
  import opr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic [W-1:0] ac,
  input  logic         lk,
  input  opr_ctl_t     ctl,
  output logic         any_hit,
  output logic         skip
);
  function automatic logic hit_any(input logic [W-1:0] a, input logic l,
                                   input opr_ctl_t c);
    logic h;
    h = (c.t_minus & a[W-1]) | (c.t_zero & (a == '0)) | (c.t_link & l);
    return h;
  endfunction

  always_comb begin
    any_hit = hit_any(ac, lk, ctl);
    // inverted sense: skip only when no selected condition holds
    skip    = ctl.invert ? ~any_hit : any_hit;
  end
endmodule

// File: rtl/opr_datapath.sv
module opr_datapath
  import opr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic [W-1:0] ac,
  input  logic         lk,
  input  logic [W-1:0] sw,
  input  opr_ctl_t     ctl,
  output logic [W-1:0] ev1_ac,
  output logic         ev1_lk,
  output logic [W-1:0] ev2_ac,
  output logic         ev2_lk,
  output logic [W-1:0] ev3_ac,
  output logic         ev3_lk
);
  localparam int unsigned RW = W + 1;

  function automatic logic [RW-1:0] ring_step(input logic [RW-1:0] r,
                                              input logic go_left);
    return go_left ? {r[RW-2:0], r[RW-1]} : {r[0], r[RW-1:1]};
  endfunction

  function automatic logic [RW-1:0] ring_rotate(input logic [RW-1:0] r,
                                                input opr_ctl_t c);
    logic [RW-1:0] t;
    t = r;
    if (c.rot_l ^ c.rot_r) begin
      t = ring_step(t, c.rot_l);
      if (c.twice) t = ring_step(t, c.rot_l);
    end
    return t;
  endfunction

  logic [RW-1:0] ring_out;

  always_comb begin
    // event 1: clears
    ev1_ac = ctl.clr_ac ? '0 : ac;
    ev1_lk = ctl.clr_lk ? 1'b0 : lk;
    // event 2: complements, then switch OR
    ev2_ac = (ctl.cpl_ac ? ~ev1_ac : ev1_ac) | (ctl.or_sw ? sw : '0);
    ev2_lk = ctl.cpl_lk ? ~ev1_lk : ev1_lk;
    // event 3: rotates on the Link+AC ring
    ring_out = ring_rotate({ev2_lk, ev2_ac}, ctl);
    ev3_ac   = ring_out[W-1:0];
    ev3_lk   = ring_out[W];
  end
endmodule

// File: rtl/opr_unit.sv
module opr_unit
  import opr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] instr,
  input  logic [W-1:0] ac_in,
  input  logic         link_in,
  input  logic [W-1:0] sw,
  output logic [W-1:0] ac_out,
  output logic         link_out,
  output logic         skip_req,
  output logic         halt_req,
  output logic         done
);
  opr_ctl_t     ctl;
  logic         any_hit;
  logic         skip_now;
  logic [W-1:0] ev1_ac, ev2_ac, ev3_ac;
  logic         ev1_lk, ev2_lk, ev3_lk;

  opr_decode u_dec (
    .field (instr[OPR_FIELD_W-1:0]),
    .ctl   (ctl)
  );

  opr_skip #(.W(W)) u_skip (
    .ac      (ac_in),
    .lk      (link_in),
    .ctl     (ctl),
    .any_hit (any_hit),
    .skip    (skip_now)
  );

  opr_datapath #(.W(W)) u_dp (
    .ac     (ac_in),
    .lk     (link_in),
    .sw     (sw),
    .ctl    (ctl),
    .ev1_ac (ev1_ac),
    .ev1_lk (ev1_lk),
    .ev2_ac (ev2_ac),
    .ev2_lk (ev2_lk),
    .ev3_ac (ev3_ac),
    .ev3_lk (ev3_lk)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_out   <= '0;
      link_out <= 1'b0;
      skip_req <= 1'b0;
      halt_req <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        ac_out   <= ev3_ac;
        link_out <= ev3_lk;
        skip_req <= skip_now;
        halt_req <= ctl.halt;
      end
    end
  end
endmodule

// File: rtl/opr_unit_chk.sv
module opr_unit_chk #(
  parameter int unsigned W = 18
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] instr,
  input logic [W-1:0] ac_in,
  input logic         link_in,
  input logic [W-1:0] ac_out,
  input logic         link_out,
  input logic         skip_req,
  input logic         halt_req,
  input logic         done,
  input logic [W-1:0] ev1_ac,
  input logic         ev1_lk,
  input logic         any_hit
);
  p_done_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (!done && $stable(ac_out) && $stable(link_out)
                && $stable(skip_req) && $stable(halt_req)));

  p_no_cond_no_skip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && instr[9:6] == 4'b0000) |=> !skip_req);

  p_hit_skips_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !instr[9] && any_hit) |=> skip_req);

  p_uncond_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && instr[9:6] == 4'b1000) |=> skip_req);

  p_clear_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && instr[12] && instr[11]) |-> (ev1_ac == '0 && !ev1_lk));

  p_clear_then_cpl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && instr[12] && instr[0] && instr[4:2] == 3'b000) |=> ac_out == '1);

  p_dual_rotate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && instr[4:3] == 2'b11 && instr[2:0] == 3'b000 && instr[12:11] == 2'b00)
      |=> (ac_out == $past(ac_in) && link_out == $past(link_in)));

  p_halt_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> halt_req == $past(instr[5]));
endmodule

bind opr_unit opr_unit_chk #(.W(W)) u_opr_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .instr    (instr),
  .ac_in    (ac_in),
  .link_in  (link_in),
  .ac_out   (ac_out),
  .link_out (link_out),
  .skip_req (skip_req),
  .halt_req (halt_req),
  .done     (done),
  .ev1_ac   (ev1_ac),
  .ev1_lk   (ev1_lk),
  .any_hit  (any_hit)
);

// File: tb/test_opr_unit.sv
`timescale 1ns/1ps
module test_opr_unit;
  localparam int W = 18;

  typedef struct {
    logic [W-1:0] ac;
    logic         lk;
    logic         skip;
    logic         halt;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] instr = '0;
  logic [W-1:0] ac_in = '0;
  logic         link_in = 1'b0;
  logic [W-1:0] sw = '0;
  logic [W-1:0] ac_out;
  logic         link_out, skip_req, halt_req, done;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  opr_unit #(.W(W)) i_opr_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .ac_in(ac_in), .link_in(link_in), .sw(sw),
    .ac_out(ac_out), .link_out(link_out), .skip_req(skip_req),
    .halt_req(halt_req), .done(done)
  );

  // reference built from the requirement text
  function automatic exp_t predict(logic [W-1:0] ins, logic [W-1:0] a0,
                                   logic l0, logic [W-1:0] s, string tag);
    exp_t e;
    logic [W:0] ring;
    logic [W-1:0] a;
    logic k, cond;
    int steps;
    cond = 1'b0;
    if (ins[6] && a0[W-1]) cond = 1'b1;
    if (ins[7] && a0 == 0) cond = 1'b1;
    if (ins[8] && l0)      cond = 1'b1;
    e.skip = ins[9] ? !cond : cond;
    e.halt = ins[5];
    a = ins[12] ? '0 : a0;
    k = ins[11] ? 1'b0 : l0;
    if (ins[0]) a = ~a;
    if (ins[1]) k = ~k;
    if (ins[2]) a = a | s;
    ring = {k, a};
    steps = (ins[3] != ins[4]) ? (ins[10] ? 2 : 1) : 0;
    for (int i = 0; i < steps; i++)
      ring = ins[3] ? {ring[W-1:0], ring[W]} : {ring[0], ring[W:1]};
    e.ac = ring[W-1:0];
    e.lk = ring[W];
    e.tag = tag;
    return e;
  endfunction

  task automatic run_op(logic [W-1:0] ins, logic [W-1:0] a, logic l,
                        logic [W-1:0] s, string tag);
    sb.push_back(predict(ins, a, l, s, tag));
    @(negedge clk);
    instr = ins; ac_in = a; link_in = l; sw = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    instr = '0; ac_in = 18'o777777; link_in = 1'b1; sw = 18'o777777;
  endtask

  task automatic chk(logic [W-1:0] act, logic [W-1:0] exp, string what, string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%o expected=%o", tag, what, act, exp);
    end
  endtask

  // monitor: compares at each falling edge
  logic [W-1:0] last_ac = '0;
  logic         last_lk = 1'b0, last_sk = 1'b0, last_ht = 1'b0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done) begin
        if (sb.size() == 0) begin
          total++; bad++;
          $display("FAIL R1 done without request actual=1 expected=0");
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(ac_out, e.ac, "ac", e.tag);
          chk({17'd0, link_out}, {17'd0, e.lk}, "link", e.tag);
          chk({17'd0, skip_req}, {17'd0, e.skip}, "skip", e.tag);
          chk({17'd0, halt_req}, {17'd0, e.halt}, "halt", e.tag);
        end
        last_ac = ac_out; last_lk = link_out;
        last_sk = skip_req; last_ht = halt_req;
      end else begin
        chk({ac_out, link_out, skip_req, halt_req},
            {last_ac, last_lk, last_sk, last_ht}, "idle hold", "R1");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] lf;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk({ac_out, link_out, skip_req, halt_req, done}, '0, "reset", "R11");
    rst_n = 1'b1;
    @(negedge clk);
    chk({17'd0, done}, '0, "done idle", "R11");

    // R4 clears
    run_op(18'o010000, 18'o123456, 1'b1, '0, "R4 cla");
    run_op(18'o004000, 18'o123456, 1'b1, '0, "R4 cll");
    // R5 complements
    run_op(18'o000001, 18'o252525, 1'b0, '0, "R5 cma");
    run_op(18'o000002, 18'o000000, 1'b0, '0, "R5 cml");
    run_op(18'o010001, 18'o070707, 1'b0, '0, "R5 cla+cma");
    run_op(18'o004002, 18'o0, 1'b0, '0, "R5 cll+cml");
    // R6 switch OR
    run_op(18'o000004, 18'o000070, 1'b0, 18'o400003, "R6 oas");
    run_op(18'o000005, 18'o777000, 1'b0, 18'o700000, "R6 cma+oas");
    run_op(18'o010004, 18'o777777, 1'b0, 18'o000123, "R6 cla+oas");
    // R7 rotates
    run_op(18'o000010, 18'o400001, 1'b0, '0, "R7 ral");
    run_op(18'o000010, 18'o000000, 1'b1, '0, "R7 ral link");
    run_op(18'o000020, 18'o000001, 1'b0, '0, "R7 rar");
    run_op(18'o000020, 18'o000000, 1'b1, '0, "R7 rar link");
    run_op(18'o010010, 18'o777777, 1'b1, '0, "R7 cla+ral");
    run_op(18'o000011, 18'o377777, 1'b0, '0, "R7 cma+ral");
    // R8 two-place
    run_op(18'o002010, 18'o600000, 1'b0, '0, "R8 rtl");
    run_op(18'o002020, 18'o000003, 1'b1, '0, "R8 rtr");
    run_op(18'o002000, 18'o135246, 1'b1, '0, "R8 alone");
    // R9 both rotate bits
    run_op(18'o000030, 18'o400001, 1'b1, '0, "R9 both");
    run_op(18'o002030, 18'o000017, 1'b0, '0, "R9 both twice");
    // R10 halt
    run_op(18'o000040, 18'o000005, 1'b0, '0, "R10 hlt");
    run_op(18'o000000, 18'o000005, 1'b0, '0, "R10 nop");
    // R2 skips
    run_op(18'o000100, 18'o400000, 1'b0, '0, "R2 sma hit");
    run_op(18'o000100, 18'o377777, 1'b0, '0, "R2 sma miss");
    run_op(18'o000200, 18'o000000, 1'b0, '0, "R2 sza hit");
    run_op(18'o000400, 18'o000001, 1'b1, '0, "R2 snl hit");
    run_op(18'o000700, 18'o000001, 1'b1, '0, "R2 any of three");
    run_op(18'o010200, 18'o000004, 1'b0, '0, "R2 sza before cla");
    run_op(18'o000411, 18'o400000, 1'b0, '0, "R2 snl before ral");
    // R3 inverted sense
    run_op(18'o001100, 18'o000001, 1'b0, '0, "R3 spa hit");
    run_op(18'o001100, 18'o400000, 1'b0, '0, "R3 spa miss");
    run_op(18'o001200, 18'o000010, 1'b0, '0, "R3 sna hit");
    run_op(18'o001400, 18'o000010, 1'b0, '0, "R3 szl hit");
    run_op(18'o001700, 18'o000010, 1'b1, '0, "R3 one true");
    run_op(18'o001700, 18'o000010, 1'b0, '0, "R3 all false");
    run_op(18'o001000, 18'o000000, 1'b1, '0, "R3 skp");
    // mixed patterns from a bench LFSR
    lf = 18'o123457;
    for (int n = 0; n < 40; n++) begin
      logic [W-1:0] a, s;
      lf = {lf[W-2:0], lf[17] ^ lf[10]};
      a = lf ^ 18'o525252;
      s = {lf[8:0], lf[17:9]};
      run_op({5'b11110, lf[12:0]}, a, lf[5], s, "R7 mixed");
    end
    repeat (4) @(negedge clk);
    chk(18'(sb.size()), '0, "queue drained", "R1");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule